// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects 32 active-low interrupt lines and turns them into two active-low processor requests: a normal request and a fast request. Every line has its own configuration word. The word chooses whether the line is sampled as a level or captured on a falling edge, which request it drives, and a 5-bit priority. When several unmasked lines are pending, each request output picks a single winner. The winner's index stays readable until software acknowledges it through a control register.

Larger systems place several copies side by side, one per bank of 32 sources. Global source number n belongs to bank n >> 5 and bit n & 0x1F. A secondary bank's normal request output is wired to one level-sensitive input of the first bank. Only the first bank (parameter `BANK_IDX` = 0) can route lines to the fast request. In any other bank the routing bit is stored as 0.

The register map uses byte addresses on an 8-bit bus. 0x00 is raw status. 0x04 is the per-line mask. 0x08 is the normal winner index and 0x0C the fast winner index. 0x10 is acknowledge. 0x14 is the global disable, with bit 0 used. The configuration word for line i is at 0x80 + 4·i. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`.

Top module: `irqc_bank`

## Requirements
- R1: After reset, the mask reads 0xFFFFFFFF, the global disable reads 1, status and every configuration word read 0, and both `irq_n` and `fiq_n` are high.
- R2: A line whose mask bit is 1 never causes a request. Writing 0 to its mask bit lets it take part in arbitration.
- R3: The configuration word at 0x80 + 4·i holds the routing in bit 0 (1 = fast request), the trigger mode in bit 1 (1 = level) and the priority in bits 6:2, and it reads back as written.
- R4: With trigger bit 0, a falling edge on a line sets its status bit. The bit stays set after the line returns high.
- R5: With trigger bit 1, the status bit reads 1 while the line is low and 0 while it is high. The mask does not affect status.
- R6: Each request output picks, among its pending unmasked lines, the one with the numerically lowest priority. Ties go to the lowest line index. The winner's index is readable at 0x08 (normal) or 0x0C (fast) and holds until acknowledged.
- R7: In a bank with a nonzero `BANK_IDX`, the routing bit is stored as 0. All its lines drive `irq_n`, and `fiq_n` stays high.
- R8: Writing control bit 0 acknowledges the normal request, bit 1 the fast request, and 0x3 both. The acknowledged output goes high on that edge and stays high for at least one cycle before a new winner can assert it. An acknowledged edge-mode winner has its status bit cleared.
- R9: Writing 0 to the status register clears all latched edge-mode status bits.
- R10: While the global disable is 1, neither output asserts. Writing 0 enables delivery.
- R11: A secondary bank's `irq_n`, fed to a level-mode line of this bank, forwards its request. The cascaded request clears only after both banks are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| src_n | input | 32 | Active-low interrupt lines |
| irq_n | output | 1 | Active-low normal request |
| fiq_n | output | 1 | Active-low fast request |

## Verification
The hardest case to reach is a cascade in which the secondary bank is still asserting while the first bank is acknowledged. The first bank's request must then come back, because its cascade input is level-sensitive. The bench builds this with a second instance whose `irq_n` drives line 5 of the main bank. It acknowledges the main bank alone, then both banks. The short quiet gap after an acknowledge is also hard to observe. The bench samples the output on the half cycle right after the acknowledge write, then again a few cycles later, while a level line is still held low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned SRC_PER_BANK = 32;
    localparam int unsigned PRIO_BITS    = 5;

    localparam logic [7:0] A_STATUS  = 8'h00;
    localparam logic [7:0] A_MASK    = 8'h04;
    localparam logic [7:0] A_IRQNUM  = 8'h08;
    localparam logic [7:0] A_FIQNUM  = 8'h0C;
    localparam logic [7:0] A_CTRL    = 8'h10;
    localparam logic [7:0] A_GDIS    = 8'h14;

    // packed layout matches the register: prio[6:2], lvl[1], fast[0]
    typedef struct packed {
        logic [PRIO_BITS-1:0] prio;
        logic                 lvl;
        logic                 fast;
    } src_cfg_t;

    typedef enum int unsigned {
        CH_IRQ = 0,
        CH_FIQ = 1
    } chan_e;

    localparam int unsigned NUM_CH = 2;

    function automatic logic is_cfg_addr(input logic [7:0] a);
        return a[7];
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);

    logic [N-1:0] prev_q;
    logic [N-1:0] stat_q;
    logic [N-1:0] fall;

    assign fall = prev_q & ~src_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '1;
            stat_q <= '0;
        end else begin
            prev_q <= src_n;
            stat_q <= (lvl & ~src_n) | (~lvl & ((stat_q & ~clr) | fall));
        end
    end

    assign stat = stat_q;

    // R4: an edge-mode status bit that was set and not cleared stays set
    p_edge_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (($past(stat_q & ~lvl & ~clr) & ~lvl & ~stat_q) == '0));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 5,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]         pend,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 valid,
    output logic [IW-1:0]        idx
);

    logic [PW-1:0] best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (!valid || prio[i] < best)) begin
                valid = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end

    // R6: a reported winner is always one of the pending lines
    always_comb begin
        if (valid) begin
            p_pick_pending_r6: assert (pend[idx]);
        end
    end

endmodule

// File: rtl/irqc_channel.sv
module irqc_channel #(
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          req_valid,
    input  logic [IW-1:0] req_idx,
    input  logic          ack,
    output logic          active,
    output logic [IW-1:0] winner
);

    logic          act_q;
    logic          gap_q;
    logic [IW-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            gap_q <= 1'b0;
            win_q <= '0;
        end else if (act_q) begin
            if (ack) begin
                act_q <= 1'b0;
                gap_q <= 1'b1;
            end
        end else if (gap_q) begin
            gap_q <= 1'b0;
        end else if (en && req_valid) begin
            act_q <= 1'b1;
            win_q <= req_idx;
        end
    end

    assign active = act_q;
    assign winner = win_q;

    // R8: after an acknowledge the request stays low for at least one cycle
    p_quiet_gap_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(act_q) |=> !act_q);

    // R6: the latched winner does not move until acknowledged
    p_winner_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (act_q && !ack) |=> (act_q && $stable(win_q)));

    // R10: a new grant only happens while delivery is enabled
    p_grant_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> $past(en));

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int unsigned BANK_IDX = 0,
    parameter int unsigned N        = SRC_PER_BANK,
    parameter int unsigned PW       = PRIO_BITS,
    parameter int unsigned AW       = 8,
    parameter int unsigned DW       = 32,
    localparam int unsigned IW      = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N-1:0]  src_n,
    output logic          irq_n,
    output logic          fiq_n
);

    localparam bit FAST_OK = (BANK_IDX == 0);

    src_cfg_t cfg_q [N];
    logic [N-1:0] mask_q;
    logic         gdis_q;

    logic [N-1:0]         lvl_v;
    logic [N-1:0]         fast_v;
    logic [N-1:0][PW-1:0] prio_v;
    logic [N-1:0]         stat;
    logic [N-1:0]         clr;
    logic [IW-1:0]        cfg_sel;

    logic [NUM_CH-1:0]          ack;
    logic [NUM_CH-1:0]          act;
    logic [NUM_CH-1:0][IW-1:0]  win;
    logic [NUM_CH-1:0][N-1:0]   pend;
    logic [NUM_CH-1:0]          arb_valid;
    logic [NUM_CH-1:0][IW-1:0]  arb_idx;
    logic [NUM_CH-1:0][N-1:0]   done_bits;

    logic wr_cfg, wr_mask, wr_gdis, wr_ctrl, clr_all;

    assign cfg_sel = addr[IW+1:2];
    assign wr_cfg  = wr_en && is_cfg_addr(8'(addr));
    assign wr_mask = wr_en && addr == AW'(A_MASK);
    assign wr_gdis = wr_en && addr == AW'(A_GDIS);
    assign wr_ctrl = wr_en && addr == AW'(A_CTRL);
    assign clr_all = wr_en && addr == AW'(A_STATUS) && wdata == '0;

    assign ack[CH_IRQ] = wr_ctrl && wdata[0];
    assign ack[CH_FIQ] = wr_ctrl && wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) cfg_q[i] <= '0;
            mask_q <= '1;
            gdis_q <= 1'b1;
        end else begin
            if (wr_cfg) begin
                cfg_q[cfg_sel].prio <= wdata[PW+1:2];
                cfg_q[cfg_sel].lvl  <= wdata[1];
                cfg_q[cfg_sel].fast <= FAST_OK ? wdata[0] : 1'b0;
            end
            if (wr_mask) mask_q <= wdata[N-1:0];
            if (wr_gdis) gdis_q <= wdata[0];
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            lvl_v[i]  = cfg_q[i].lvl;
            fast_v[i] = cfg_q[i].fast;
            prio_v[i] = cfg_q[i].prio;
        end
    end

    irqc_capture #(.N(N)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .src_n (src_n),
        .lvl   (lvl_v),
        .clr   (clr),
        .stat  (stat)
    );

    assign pend[CH_IRQ] = stat & ~mask_q & ~fast_v;
    assign pend[CH_FIQ] = stat & ~mask_q &  fast_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        irqc_arbiter #(.N(N), .PW(PW)) u_arb (
            .pend  (pend[c]),
            .prio  (prio_v),
            .valid (arb_valid[c]),
            .idx   (arb_idx[c])
        );

        irqc_channel #(.IW(IW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .en        (!gdis_q),
            .req_valid (arb_valid[c]),
            .req_idx   (arb_idx[c]),
            .ack       (ack[c]),
            .active    (act[c]),
            .winner    (win[c])
        );

        assign done_bits[c] = (act[c] && ack[c]) ? (N'(1) << win[c]) : '0;
    end

    assign clr = {N{clr_all}} | done_bits[CH_IRQ] | done_bits[CH_FIQ];

    assign irq_n = !(act[CH_IRQ] && !gdis_q);
    assign fiq_n = !(act[CH_FIQ] && !gdis_q);

    always_comb begin
        rdata = '0;
        if (is_cfg_addr(8'(addr))) begin
            rdata[PW+1:0] = cfg_q[cfg_sel];
        end else begin
            case (addr)
                AW'(A_STATUS): rdata[N-1:0]  = stat;
                AW'(A_MASK):   rdata[N-1:0]  = mask_q;
                AW'(A_IRQNUM): rdata[IW-1:0] = win[CH_IRQ];
                AW'(A_FIQNUM): rdata[IW-1:0] = win[CH_FIQ];
                AW'(A_GDIS):   rdata[0]      = gdis_q;
                default:       rdata         = '0;
            endcase
        end
    end

    // R2: a grant never goes to a line that was masked
    p_masked_no_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(act[CH_IRQ]) |-> !(($past(mask_q) >> win[CH_IRQ]) & N'(1)));

    // R7: secondary banks never raise the fast request
    if (!FAST_OK) begin : g_nofast
        p_no_fast_r7: assert property (@(posedge clk) disable iff (rst)
            fiq_n && !act[CH_FIQ]);
    end

endmodule

// File: tb/tb_irqc_bank.sv
module tb_irqc_bank;
    import irqc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr0 = 1'b0, wr1 = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [31:0] stim_n = '1;
    logic [31:0] b1_stim_n = '1;
    logic        irq_n, fiq_n, b1_irq_n, b1_fiq_n;
    logic [31:0] dut_src;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    assign dut_src = {stim_n[31:6], b1_irq_n, stim_n[4:0]};

    irqc_bank #(.BANK_IDX(0)) dut (
        .clk(clk), .rst(rst), .wr_en(wr0), .addr(addr), .wdata(wdata),
        .rdata(rdata0), .src_n(dut_src), .irq_n(irq_n), .fiq_n(fiq_n)
    );

    irqc_bank #(.BANK_IDX(1)) u_b1 (
        .clk(clk), .rst(rst), .wr_en(wr1), .addr(addr), .wdata(wdata),
        .rdata(rdata1), .src_n(b1_stim_n), .irq_n(b1_irq_n), .fiq_n(b1_fiq_n)
    );

    typedef struct packed {
        logic [31:0] req;
        logic [31:0] mask;
        logic        hit;
        logic [4:0]  idx;
    } vec_t;

    // line priorities: 3->5, 9->5, 20->2, 30->0, rest 16; all level mode
    localparam vec_t VECS [7] = '{
        '{32'h0000_0208, 32'h0000_0000, 1'b1, 5'd3},
        '{32'h0010_0200, 32'h0000_0000, 1'b1, 5'd20},
        '{32'h4010_0000, 32'h4000_0000, 1'b1, 5'd20},
        '{32'h0000_0006, 32'h0000_0000, 1'b1, 5'd1},
        '{32'h4000_0001, 32'h0000_0000, 1'b1, 5'd30},
        '{32'h0000_0200, 32'h0000_0200, 1'b0, 5'd0},
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 5'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int bank, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (bank == 0) wr0 = 1'b1; else wr1 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic rd(input int bank, input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = (bank == 0) ? rdata0 : rdata1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        check("R1 irq_n", {31'b0, irq_n}, 32'd1);
        check("R1 fiq_n", {31'b0, fiq_n}, 32'd1);
        rd(0, A_MASK, r);   check("R1 mask", r, 32'hFFFF_FFFF);
        rd(0, A_GDIS, r);   check("R1 gdis", r, 32'd1);
        rd(0, A_STATUS, r); check("R1 status", r, 32'd0);
        rd(0, 8'h80, r);    check("R1 cfg0", r, 32'd0);

        // R3 configuration words
        for (int i = 0; i < 32; i++) begin
            logic [31:0] v;
            v = 32'h42;
            if (i == 3 || i == 9) v = 32'h16;
            if (i == 20) v = 32'h0A;
            if (i == 30) v = 32'h02;
            wr(0, 8'h80 + 8'(4 * i), v);
        end
        rd(0, 8'h80 + 8'd80, r); check("R3 cfg20 readback", r, 32'h0A);
        rd(0, 8'h80 + 8'd12, r); check("R3 cfg3 readback", r, 32'h16);

        // R10 global disable, then R5/R8 on a level line
        wr(0, A_MASK, ~32'h2);
        stim_n[1] = 1'b0;
        cyc(4);
        check("R10 blocked while disabled", {31'b0, irq_n}, 32'd1);
        wr(0, A_GDIS, 32'd0);
        cyc(4);
        check("R10 delivered after enable", {31'b0, irq_n}, 32'd0);
        rd(0, A_STATUS, r); check("R5 level status low input", r, 32'h2);
        wr(0, A_CTRL, 32'd1);
        check("R8 output high after ack", {31'b0, irq_n}, 32'd1);
        cyc(4);
        check("R8 level line re-arbitrated", {31'b0, irq_n}, 32'd0);
        stim_n[1] = 1'b1;
        cyc(2);
        rd(0, A_STATUS, r); check("R5 level status follows input", r, 32'h0);
        wr(0, A_CTRL, 32'd1);
        cyc(3);

        // R6 / R2 table of arbitration vectors
        foreach (VECS[k]) begin
            wr(0, A_MASK, VECS[k].mask);
            stim_n = ~VECS[k].req;
            cyc(4);
            check($sformatf("R6 R2 vec%0d irq_n", k), {31'b0, irq_n}, {31'b0, ~VECS[k].hit});
            if (VECS[k].hit) begin
                rd(0, A_IRQNUM, r);
                check($sformatf("R6 vec%0d winner", k), r, {27'b0, VECS[k].idx});
            end
            stim_n = '1;
            wr(0, A_CTRL, 32'd1);
            cyc(3);
        end

        // R4 / R8 / R9 edge mode on line 12
        wr(0, 8'h80 + 8'd48, 32'h04);
        wr(0, A_MASK, ~(32'h1 << 12));
        @(negedge clk); stim_n[12] = 1'b0;
        @(negedge clk); stim_n[12] = 1'b1;
        cyc(4);
        rd(0, A_STATUS, r); check("R4 edge sticky", r, 32'h1000);
        check("R4 edge request", {31'b0, irq_n}, 32'd0);
        rd(0, A_IRQNUM, r); check("R6 edge winner", r, 32'd12);
        wr(0, A_CTRL, 32'd1);
        rd(0, A_STATUS, r); check("R8 edge status cleared by ack", r, 32'h0);
        cyc(4);
        check("R8 edge stays idle", {31'b0, irq_n}, 32'd1);
        wr(0, A_GDIS, 32'd1);
        @(negedge clk); stim_n[12] = 1'b0;
        @(negedge clk); stim_n[12] = 1'b1;
        cyc(2);
        rd(0, A_STATUS, r); check("R9 latched before clear", r, 32'h1000);
        wr(0, A_STATUS, 32'd0);
        rd(0, A_STATUS, r); check("R9 cleared by zero write", r, 32'h0);
        wr(0, A_GDIS, 32'd0);
        cyc(4);
        check("R9 nothing left pending", {31'b0, irq_n}, 32'd1);

        // R7 / R8 fast routing on bank 0 with both requests
        wr(0, 8'h80 + 8'd56, 32'h03);
        wr(0, A_MASK, ~((32'h1 << 14) | 32'h2));
        stim_n[14] = 1'b0; stim_n[1] = 1'b0;
        cyc(4);
        check("R7 fast asserted", {31'b0, fiq_n}, 32'd0);
        check("R7 normal asserted", {31'b0, irq_n}, 32'd0);
        rd(0, A_FIQNUM, r); check("R6 fast winner", r, 32'd14);
        rd(0, A_IRQNUM, r); check("R6 normal winner", r, 32'd1);
        wr(0, A_CTRL, 32'd2);
        check("R8 fast ack only fast", {30'b0, irq_n, fiq_n}, 32'd1);
        stim_n[14] = 1'b1; stim_n[1] = 1'b1;
        wr(0, A_CTRL, 32'd3);
        cyc(4);
        check("R8 joint ack", {30'b0, irq_n, fiq_n}, 32'd3);

        // R7 secondary bank, R11 cascade into line 5
        wr(1, 8'h80 + 8'd28, 32'h03);
        rd(1, 8'h80 + 8'd28, r); check("R7 routing forced in bank1", r, 32'h02);
        wr(1, A_MASK, ~(32'h1 << 7));
        wr(1, A_GDIS, 32'd0);
        wr(0, A_MASK, ~(32'h1 << 5));
        b1_stim_n[7] = 1'b0;
        cyc(6);
        check("R7 bank1 drives normal", {30'b0, b1_irq_n, b1_fiq_n}, 32'd1);
        check("R11 cascade reaches bank0", {31'b0, irq_n}, 32'd0);
        rd(0, A_IRQNUM, r); check("R11 cascade winner", r, 32'd5);
        wr(0, A_CTRL, 32'd1);
        cyc(4);
        check("R11 bank0-only ack re-asserts", {31'b0, irq_n}, 32'd0);
        b1_stim_n[7] = 1'b1;
        wr(1, A_CTRL, 32'd1);
        wr(0, A_CTRL, 32'd1);
        cyc(4);
        check("R11 both acked idle", {31'b0, irq_n}, 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule